// File: doc/BRIEF.md
# Dual Alarm Match and Interrupt Unit

This block holds two alarm register sets and compares each against the live time once per second. Each set has four bytes: seconds, minutes, hours and day of week.

The time counter and the serial register bus are outside the block. The counter supplies a one-cycle `sec_tick` pulse together with the freshly updated time bytes. The bus logic supplies decoded single-cycle read and write strobes, a register address and write data, and it takes the read data one cycle later.

When every field of an alarm set agrees with the live time on a tick, that alarm's pending flag sets. A field with its top bit set is ignored in the comparison. A pending flag drives an interrupt output only while that alarm's interrupt enable is set. A routing bit chooses between two arrangements:
- both alarms share the active-low output `irq0_n`;
- alarm 1 has its own active-low output `irq1_n`.

A flag stays set until software clears it. Software can clear it by reading any byte of that alarm's set, or by writing a zero into its position in the status register.

Top module: `alrm_unit`

## Requirements
- R1: After reset, all alarm bytes, the control bits and both pending flags are zero, and both `irq0_n` and `irq1_n` are high.
- R2: The alarm 0 bytes sit at addresses 0x07 to 0x0A and the alarm 1 bytes at 0x0B to 0x0E. In each set the order is seconds, minutes, hours, day of week. A write stores the byte and a read returns it on `rdata` one cycle after the strobe.
- R3: On a `sec_tick`, an alarm matches when each of its fields either has bit 7 set (ignored) or equals the corresponding live time byte in all eight bits. The 12-hour and PM bits of the hours byte are part of that comparison. `live_time` packs seconds in bits 7:0, minutes in 15:8, hours in 23:16 and day of week in 31:24.
- R4: A match sets that alarm's flag in the status register (address 0x10, bit 0 for alarm 0 and bit 1 for alarm 1) whether or not its interrupt is enabled. Flags never set without a tick.
- R5: A read of any byte of an alarm's set clears that alarm's flag and leaves the other alarm's flag unchanged.
- R6: A write to the status register clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R7: The control register is at address 0x0F. Bit 0 enables the alarm 0 interrupt, bit 1 enables the alarm 1 interrupt, and bit 2 selects routing. With bit 2 clear, both alarms drive `irq0_n`. With bit 2 set, alarm 1 drives `irq1_n` and never `irq0_n`. An output is low only while a routed flag and its enable are both set, and it follows them one cycle later.
- R8: An asserted interrupt output stays low across later non-matching ticks until its flag or its enable is cleared.
- R9: When a tick matches in the same cycle as a clearing read or a status write for that alarm, the flag ends up set.
- R10: Writes to addresses outside 0x07 to 0x10 have no effect, and reads there return 0. Control bits 7:3 and status bits 7:2 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse after the time counter updates |
| live_time | input | 32 | Current time bytes: {day of week, hours, minutes, seconds} |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered one cycle after `rd_en` |
| irq0_n | output | 1 | Active-low interrupt, intended for an open-drain pad |
| irq1_n | output | 1 | Active-low interrupt for alarm 1 when routed |

## Verification
The assertions assume four things about the inputs:
- the strobes are single-cycle and come from a bus decoder that issues at most one access per cycle;
- `sec_tick` is a pulse, not a level;
- the clearing and hold properties are written only for cycles with no tick;
- a flag can only be raised by a tick.

The stimulus respects these assumptions. Each bus access and each tick is one cycle wide and separated by idle cycles. The only deliberate overlap of a tick with a clearing read is confined to the test that targets the priority between them.

// File: rtl/alrm_pkg.sv
package alrm_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_ALARMS = 2;

  typedef struct packed {
    logic       route;
    logic [1:0] ien;
  } alrm_ctrl_t;
endpackage

// File: rtl/alrm_slot.sv
module alrm_slot #(
  parameter int DATA_W     = 8,
  parameter int NUM_FIELDS = 4,
  parameter int ADDR_W     = 5,
  parameter int BASE       = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NUM_FIELDS*DATA_W-1:0] live_time,
  output logic                         hit,
  output logic [DATA_W-1:0]            rd_byte,
  output logic                         match
);
  localparam int IDX_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1;

  logic [DATA_W-1:0]     fld_q [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] field_ok;
  logic [IDX_W-1:0]      idx;
  int                    addr_i;

  always_comb begin
    addr_i = int'(addr);
    hit    = (addr_i >= BASE) && (addr_i < BASE + NUM_FIELDS);
    idx    = IDX_W'(addr_i - BASE);
  end

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)
        fld_q[f] <= '0;
      else if (wr_en && hit && (idx == IDX_W'(f)))
        fld_q[f] <= wdata;
    end

    // top bit of the stored byte masks the field; otherwise full byte compare
    assign field_ok[f] = fld_q[f][DATA_W-1] |
                         (fld_q[f] == live_time[f*DATA_W +: DATA_W]);
  end

  always_comb begin
    rd_byte = '0;
    for (int f = 0; f < NUM_FIELDS; f++)
      if (idx == IDX_W'(f)) rd_byte = fld_q[f];
  end

  assign match = &field_ok;
endmodule

// File: rtl/alrm_flags.sv
module alrm_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [N-1:0] match,
  input  logic [N-1:0] rd_clr,
  input  logic         stat_wr,
  input  logic [N-1:0] stat_data,
  output logic [N-1:0] flags
);
  logic [N-1:0] clr;
  logic [N-1:0] set;

  always_comb begin
    clr = rd_clr | (stat_wr ? ~stat_data : '0);
    set = tick ? match : '0;
  end

  // a fresh match outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr) | set;
  end
endmodule

// File: rtl/alrm_irq.sv
module alrm_irq
  import alrm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] flags,
  input  alrm_ctrl_t ctrl,
  output logic       irq0_n,
  output logic       irq1_n
);
  logic [1:0] act;
  logic       drive0;
  logic       drive1;

  always_comb begin
    act    = flags & ctrl.ien;
    drive0 = act[0] | (act[1] & ~ctrl.route);
    drive1 = act[1] & ctrl.route;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0_n <= 1'b1;
      irq1_n <= 1'b1;
    end else begin
      irq0_n <= ~drive0;
      irq1_n <= ~drive1;
    end
  end
endmodule

// File: rtl/alrm_unit.sv
module alrm_unit
  import alrm_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int NUM_FIELDS = 4,
  parameter int ALM_BASE   = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sec_tick,
  input  logic [NUM_FIELDS*BYTE_W-1:0] live_time,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BYTE_W-1:0]            wdata,
  output logic [BYTE_W-1:0]            rdata,
  output logic                         irq0_n,
  output logic                         irq1_n
);
  localparam int CTRL_ADDR = ALM_BASE + NUM_ALARMS * NUM_FIELDS;
  localparam int STAT_ADDR = CTRL_ADDR + 1;

  logic [NUM_ALARMS-1:0] slot_hit;
  logic [NUM_ALARMS-1:0] slot_match;
  logic [BYTE_W-1:0]     slot_byte [NUM_ALARMS];
  logic [NUM_ALARMS-1:0] flag_q;
  alrm_ctrl_t            ctrl_q;
  logic                  route_q;
  logic                  ctrl_sel;
  logic                  stat_sel;
  logic [BYTE_W-1:0]     rd_next;

  assign ctrl_sel = (int'(addr) == CTRL_ADDR);
  assign stat_sel = (int'(addr) == STAT_ADDR);
  assign route_q  = ctrl_q.route;

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_slot
    alrm_slot #(
      .DATA_W    (BYTE_W),
      .NUM_FIELDS(NUM_FIELDS),
      .ADDR_W    (ADDR_W),
      .BASE      (ALM_BASE + a * NUM_FIELDS)
    ) i_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .live_time(live_time),
      .hit      (slot_hit[a]),
      .rd_byte  (slot_byte[a]),
      .match    (slot_match[a])
    );
  end

  alrm_flags #(.N(NUM_ALARMS)) i_flags (
    .clk      (clk),
    .rst      (rst),
    .tick     (sec_tick),
    .match    (slot_match),
    .rd_clr   (slot_hit & {NUM_ALARMS{rd_en}}),
    .stat_wr  (wr_en & stat_sel),
    .stat_data(wdata[NUM_ALARMS-1:0]),
    .flags    (flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (wr_en && ctrl_sel)
      ctrl_q <= alrm_ctrl_t'(wdata[2:0]);
  end

  always_comb begin
    rd_next = '0;
    for (int a = 0; a < NUM_ALARMS; a++)
      if (slot_hit[a]) rd_next = slot_byte[a];
    if (ctrl_sel) rd_next = BYTE_W'(ctrl_q);
    if (stat_sel) rd_next = BYTE_W'(flag_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  alrm_irq i_irq (
    .clk   (clk),
    .rst   (rst),
    .flags (flag_q),
    .ctrl  (ctrl_q),
    .irq0_n(irq0_n),
    .irq1_n(irq1_n)
  );
endmodule

// File: rtl/alrm_unit_chk.sv
module alrm_unit_chk #(
  parameter int ADDR_W   = 5,
  parameter int ALM_BASE = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              sec_tick,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              irq0_n,
  input logic              irq1_n,
  input logic [1:0]        flag_q,
  input logic              route_q
);
  localparam int STAT_ADDR = ALM_BASE + 9;

  logic rd_a0;
  logic stat_zero;
  assign rd_a0     = rd_en && (int'(addr) >= ALM_BASE) && (int'(addr) < ALM_BASE + 4);
  assign stat_zero = wr_en && (int'(addr) == STAT_ADDR) && (wdata[1:0] == 2'b00);

  // R4: flags only rise after a tick
  a_r4_flag_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag_q[0]) || $rose(flag_q[1])) |-> $past(sec_tick));

  // R5: reading alarm 0 bytes clears its flag
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_a0 && !sec_tick) |=> !flag_q[0]);

  // R6: writing zero to status clears both flags
  a_r6_status_zero_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_zero && !sec_tick) |=> (flag_q == 2'b00));

  // R7: the second output needs routing
  a_r7_irq1_needs_route: assert property (@(posedge clk) disable iff (rst)
    !irq1_n |-> $past(route_q));

  // R8: an asserted output holds through quiet cycles
  a_r8_irq0_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(irq0_n) && !$past(wr_en) && !$past(rd_en) &&
     !$past(wr_en, 2) && !$past(rd_en, 2)) |-> !irq0_n);
endmodule

bind alrm_unit alrm_unit_chk #(.ADDR_W(ADDR_W), .ALM_BASE(ALM_BASE)) i_alrm_unit_chk (
  .clk     (clk),
  .rst     (rst),
  .sec_tick(sec_tick),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .irq0_n  (irq0_n),
  .irq1_n  (irq1_n),
  .flag_q  (flag_q),
  .route_q (route_q)
);

// File: tb/test_alrm_unit.sv
module test_alrm_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_tick = 1'b0;
  logic [31:0] live_time = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq0_n;
  logic        irq1_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  alrm_unit i_alrm_unit (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .live_time(live_time),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq0_n(irq0_n), .irq1_n(irq1_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
    @(negedge clk);
  endtask

  task automatic tick(input logic [7:0] wd, input logic [7:0] h,
                      input logic [7:0] m, input logic [7:0] s);
    @(negedge clk); sec_tick = 1'b1; live_time = {wd, h, m, s};
    @(negedge clk); sec_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd(5'h10, rv); chk("R1 status", rv, 8'h00);
    rd(5'h0F, rv); chk("R1 control", rv, 8'h00);
    rd(5'h09, rv); chk("R1 alarm byte", rv, 8'h00);
    chk("R1 irq0_n", {7'd0, irq0_n}, 8'h01);
    chk("R1 irq1_n", {7'd0, irq1_n}, 8'h01);
  endtask

  task automatic t_regs;
    wr(5'h07, 8'h15); wr(5'h08, 8'h30); wr(5'h09, 8'h08); wr(5'h0A, 8'h03);
    wr(5'h0E, 8'h86);
    rd(5'h07, rv); chk("R2 alm0 sec", rv, 8'h15);
    rd(5'h09, rv); chk("R2 alm0 hour", rv, 8'h08);
    rd(5'h0A, rv); chk("R2 alm0 wday", rv, 8'h03);
    rd(5'h0E, rv); chk("R2 alm1 wday", rv, 8'h86);
  endtask

  task automatic t_match_no_irq;
    wr(5'h10, 8'h00);
    tick(8'h03, 8'h08, 8'h30, 8'h14);
    rd(5'h10, rv); chk("R3 near miss", rv & 8'h01, 8'h00);
    tick(8'h03, 8'h08, 8'h30, 8'h15);
    rd(5'h10, rv); chk("R4 flag without enable", rv & 8'h01, 8'h01);
    chk("R4 no irq when disabled", {7'd0, irq0_n}, 8'h01);
    wr(5'h10, 8'h00);
    rd(5'h10, rv); chk("R6 status zero clears", rv, 8'h00);
  endtask

  task automatic t_dont_care;
    wr(5'h0B, 8'h80); wr(5'h0C, 8'h80); wr(5'h0D, 8'h80); wr(5'h0E, 8'h80);
    tick(8'h05, 8'h22, 8'h41, 8'h59);
    rd(5'h10, rv); chk("R3 all ignored matches", rv & 8'h02, 8'h02);
    wr(5'h10, 8'h00);
    wr(5'h0B, 8'h45);
    tick(8'h01, 8'h11, 8'h12, 8'h44);
    rd(5'h10, rv); chk("R3 seconds only miss", rv & 8'h02, 8'h00);
    tick(8'h07, 8'h11, 8'h12, 8'h45);
    rd(5'h10, rv); chk("R3 seconds only hit", rv & 8'h02, 8'h02);
    wr(5'h10, 8'h00);
  endtask

  task automatic t_hour_bits;
    wr(5'h09, 8'h68); wr(5'h0A, 8'h80);
    tick(8'h03, 8'h28, 8'h30, 8'h15);
    rd(5'h10, rv); chk("R3 12h bit compared", rv & 8'h01, 8'h00);
    tick(8'h03, 8'h68, 8'h30, 8'h15);
    rd(5'h10, rv); chk("R3 12h PM match", rv & 8'h01, 8'h01);
    wr(5'h10, 8'h00);
  endtask

  task automatic t_gate_and_shared;
    tick(8'h00, 8'h00, 8'h00, 8'h45);
    chk("R7 gated off", {7'd0, irq0_n}, 8'h01);
    wr(5'h0F, 8'h02);
    chk("R7 shared irq0", {7'd0, irq0_n}, 8'h00);
    chk("R7 shared irq1 idle", {7'd0, irq1_n}, 8'h01);
    tick(8'h00, 8'h00, 8'h00, 8'h10);
    tick(8'h00, 8'h00, 8'h00, 8'h11);
    chk("R8 holds across ticks", {7'd0, irq0_n}, 8'h00);
    rd(5'h0C, rv);
    chk("R5 read clears irq", {7'd0, irq0_n}, 8'h01);
    rd(5'h10, rv); chk("R5 flag cleared", rv, 8'h00);
  endtask

  task automatic t_routed;
    wr(5'h0F, 8'h07);
    rd(5'h0F, rv); chk("R7 control readback", rv, 8'h07);
    tick(8'h00, 8'h00, 8'h00, 8'h45);
    chk("R7 routed irq1", {7'd0, irq1_n}, 8'h00);
    chk("R7 routed irq0 idle", {7'd0, irq0_n}, 8'h01);
    tick(8'h03, 8'h68, 8'h30, 8'h15);
    chk("R7 alarm0 irq0", {7'd0, irq0_n}, 8'h00);
    wr(5'h10, 8'h02);
    rd(5'h10, rv); chk("R6 partial clear", rv, 8'h02);
    chk("R6 irq0 released", {7'd0, irq0_n}, 8'h01);
    chk("R6 irq1 kept", {7'd0, irq1_n}, 8'h00);
    wr(5'h10, 8'h00);
  endtask

  task automatic t_race;
    tick(8'h03, 8'h68, 8'h30, 8'h15);
    @(negedge clk);
    sec_tick = 1'b1; live_time = 32'h03683015; rd_en = 1'b1; addr = 5'h07;
    @(negedge clk); sec_tick = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    rd(5'h10, rv); chk("R9 match beats clear", rv & 8'h01, 8'h01);
    wr(5'h10, 8'h00);
  endtask

  task automatic t_unused;
    wr(5'h11, 8'hFF);
    rd(5'h11, rv); chk("R10 unused reads zero", rv, 8'h00);
    wr(5'h0F, 8'hF8);
    rd(5'h0F, rv); chk("R10 control upper bits", rv, 8'h00);
    rd(5'h10, rv); chk("R10 status untouched", rv, 8'h00);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_match_no_irq();
    t_dont_care();
    t_hour_bits();
    t_gate_and_shared();
    t_routed();
    t_race();
    t_unused();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule